// File: doc/BRIEF.md
# Lane-Selectable Packed Integer Subtractor

This block is a registered SIMD subtract unit. Each operation presents a destination operand and a source operand of up to 128 bits, an escape byte, an opcode byte and a wide-operation flag. The unit subtracts the source from the destination separately in every lane and returns the packed difference one cycle later. The opcode byte picks 8, 16 or 32-bit lanes, and the wide flag picks a 128-bit or a 64-bit operation.

One shared subtractor does the work for all lane widths. Its borrow chain is cut at the lane boundaries that the decoded opcode picks. Each lane keeps only the low bits of its difference, so the same result serves signed and unsigned data. The unit has no flag outputs. An unrecognised escape or opcode byte is reported on an illegal-opcode output, and the held result stays as it was. A valid/ready handshake is used on both sides, so a consumer that is not ready stalls the unit.

Top module: `packed_sub_unit`

## Requirements
- R1: Every lane computes destination minus source, never source minus destination (for example 0x05 − 0x03 gives 0x02).
- R2: With escape byte 0x0F, opcode 0xF8 selects 8-bit lanes, 0xF9 selects 16-bit lanes and 0xFA selects 32-bit lanes.
- R3: With `in_wide` = 1 all 128 bits are processed (16, 8 or 4 lanes). With `in_wide` = 0 only bits 63:0 are processed (8, 4 or 2 lanes).
- R4: In a 64-bit operation, bits 127:64 of the result are zero.
- R5: A lane result that is out of range wraps to its low lane-width bits, and no borrow crosses a lane boundary (0x00…00 minus 0x01 in every lane gives all ones in every lane).
- R6: An escape byte other than 0x0F, or an opcode byte outside 0xF8 to 0xFA, raises `out_illegal` with `out_valid`. `out_result` then keeps the value from the last legal operation.
- R7: An operation accepted at a clock edge appears on `out_valid`/`out_result` right after that edge (one cycle of latency).
- R8: While `out_valid` = 1 and `out_ready` = 0, the outputs stay stable and `in_ready` = 0. `in_ready` = 1 whenever the output register is empty or is being drained, which allows back-to-back operations.
- R9: After reset, `out_valid` = 0, `out_illegal` = 0, `out_result` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented |
| in_ready | output | 1 | The unit can accept an operation |
| in_escape | input | 8 | Escape byte, must be 0x0F |
| in_opcode | input | 8 | Opcode byte that picks the lane width |
| in_wide | input | 1 | 1 = 128-bit operation, 0 = 64-bit |
| in_dst | input | 128 | Destination operand (minuend) |
| in_src | input | 128 | Source operand (subtrahend) |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | The consumer takes the result |
| out_result | output | 128 | Packed difference |
| out_illegal | output | 1 | The held operation had an unrecognised escape or opcode |

## Verification
Two things can happen in the same cycle: the held result drains and a new operation is accepted. The bench provokes this by keeping `in_valid` and `out_ready` high over consecutive edges, and checks each cycle's output against the previous operand pair. It also stalls the output with `out_ready` low while a second operation waits, and checks that the held result is unchanged and the waiting operation is taken in the same edge that releases the stall. An illegal operation placed directly after a legal one checks that the kept result is the legal one.

// File: rtl/psub_pkg.sv
package psub_pkg;

    typedef enum logic [1:0] {
        LANE_B8  = 2'd0,
        LANE_H16 = 2'd1,
        LANE_S32 = 2'd2
    } lane_sel_e;

    localparam logic [7:0] ESC_CODE  = 8'h0F;
    localparam logic [7:0] OPC_SUB8  = 8'hF8;
    localparam logic [7:0] OPC_SUB16 = 8'hF9;
    localparam logic [7:0] OPC_SUB32 = 8'hFA;

endpackage

// File: rtl/psub_decode.sv
module psub_decode
    import psub_pkg::*;
(
    input  logic [7:0] escape_i,
    input  logic [7:0] opcode_i,
    output lane_sel_e  lane_sel_o,
    output logic       illegal_o
);

    logic esc_ok;

    always_comb begin
        esc_ok     = (escape_i == ESC_CODE);
        lane_sel_o = LANE_B8;
        illegal_o  = 1'b0;
        unique case (opcode_i)
            OPC_SUB8:  lane_sel_o = LANE_B8;
            OPC_SUB16: lane_sel_o = LANE_H16;
            OPC_SUB32: lane_sel_o = LANE_S32;
            default:   illegal_o  = 1'b1;
        endcase
        if (!esc_ok) begin
            illegal_o = 1'b1;
        end
    end

endmodule

// File: rtl/psub_carry_breaks.sv
module psub_carry_breaks
    import psub_pkg::*;
#(
    parameter int NBYTES = 16
) (
    input  lane_sel_e         lane_sel_i,
    output logic [NBYTES-1:0] lane_start_o
);

    logic sel_b8;
    logic sel_h16;
    logic sel_s32;

    always_comb begin
        sel_b8  = (lane_sel_i == LANE_B8);
        sel_h16 = (lane_sel_i == LANE_H16);
        sel_s32 = (lane_sel_i == LANE_S32);
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_start
        if (i == 0) begin : g_first
            assign lane_start_o[i] = 1'b1;
        end else if (i % 4 == 0) begin : g_dword
            assign lane_start_o[i] = sel_b8 | sel_h16 | sel_s32;
        end else if (i % 2 == 0) begin : g_word
            assign lane_start_o[i] = sel_b8 | sel_h16;
        end else begin : g_byte
            assign lane_start_o[i] = sel_b8;
        end
    end

endmodule

// File: rtl/psub_lane_chain.sv
module psub_lane_chain #(
    parameter int DATA_W = 128,
    localparam int NBYTES = DATA_W / 8
) (
    input  logic [DATA_W-1:0] minuend_i,
    input  logic [DATA_W-1:0] subtrahend_i,
    input  logic [NBYTES-1:0] lane_start_i,
    output logic [DATA_W-1:0] diff_o
);

    logic [NBYTES-1:0] carry_in;
    logic [NBYTES-1:0] carry_out;

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        logic [7:0] a_byte;
        logic [7:0] nb_byte;
        logic [8:0] sum;

        assign a_byte  = minuend_i[8*i +: 8];
        assign nb_byte = ~subtrahend_i[8*i +: 8];

        if (i == 0) begin : g_cin0
            assign carry_in[i] = lane_start_i[i];
        end else begin : g_cinn
            assign carry_in[i] = lane_start_i[i] | carry_out[i-1];
        end

        assign sum               = {1'b0, a_byte} + {1'b0, nb_byte} + {8'b0, carry_in[i]};
        assign diff_o[8*i +: 8]  = sum[7:0];
        assign carry_out[i]      = sum[8] & ~((i + 1 < NBYTES) ? lane_start_i[(i + 1) % NBYTES] : 1'b0);
    end

endmodule

// File: rtl/psub_width_mask.sv
module psub_width_mask #(
    parameter int DATA_W   = 128,
    parameter int NARROW_W = 64,
    localparam int NBYTES  = DATA_W / 8,
    localparam int NARROW_BYTES = NARROW_W / 8
) (
    input  logic [DATA_W-1:0] diff_i,
    input  logic              wide_i,
    output logic [DATA_W-1:0] masked_o
);

    for (genvar i = 0; i < NBYTES; i++) begin : g_mask
        if (i < NARROW_BYTES) begin : g_low
            assign masked_o[8*i +: 8] = diff_i[8*i +: 8];
        end else begin : g_high
            assign masked_o[8*i +: 8] = diff_i[8*i +: 8] & {8{wide_i}};
        end
    end

endmodule

// File: rtl/packed_sub_unit.sv
module packed_sub_unit
    import psub_pkg::*;
#(
    parameter int DATA_W   = 128,
    parameter int NARROW_W = 64,
    localparam int NBYTES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_escape,
    input  logic [7:0]        in_opcode,
    input  logic              in_wide,
    input  logic [DATA_W-1:0] in_dst,
    input  logic [DATA_W-1:0] in_src,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_result,
    output logic              out_illegal
);

    typedef struct packed {
        logic              valid;
        logic              illegal;
        logic              narrow;
        logic [DATA_W-1:0] result;
    } state_t;

    state_t st_d, st_q;

    lane_sel_e         dec_lane_sel;
    logic              dec_illegal;
    logic [NBYTES-1:0] lane_start;
    logic [DATA_W-1:0] raw_diff;
    logic [DATA_W-1:0] masked_diff;
    logic              fire_in;

    psub_decode u_decode (
        .escape_i   (in_escape),
        .opcode_i   (in_opcode),
        .lane_sel_o (dec_lane_sel),
        .illegal_o  (dec_illegal)
    );

    psub_carry_breaks #(.NBYTES(NBYTES)) u_breaks (
        .lane_sel_i   (dec_lane_sel),
        .lane_start_o (lane_start)
    );

    psub_lane_chain #(.DATA_W(DATA_W)) u_chain (
        .minuend_i    (in_dst),
        .subtrahend_i (in_src),
        .lane_start_i (lane_start),
        .diff_o       (raw_diff)
    );

    psub_width_mask #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_mask (
        .diff_i   (raw_diff),
        .wide_i   (in_wide),
        .masked_o (masked_diff)
    );

    assign in_ready = !st_q.valid || out_ready;
    assign fire_in  = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && out_ready) begin
            st_d.valid = 1'b0;
        end
        if (fire_in) begin
            st_d.valid   = 1'b1;
            st_d.illegal = dec_illegal;
            if (!dec_illegal) begin
                st_d.result = masked_diff;
                st_d.narrow = !in_wide;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_result  = st_q.result;
    assign out_illegal = st_q.illegal;

    AST_LANE0_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        fire_in && !dec_illegal |=> out_result[7:0] == $past(in_dst[7:0] - in_src[7:0])); // R1
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid && !st_q.illegal && st_q.narrow |-> out_result[DATA_W-1:NARROW_W] == '0); // R4
    AST_ILLEGAL_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        fire_in && dec_illegal |=> out_illegal && $stable(out_result)); // R6
    AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        fire_in |=> out_valid); // R7
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_illegal)); // R8
    AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R8

endmodule

// File: tb/tb_packed_sub_unit.sv
`timescale 1ns/1ps
module tb_packed_sub_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [7:0]   in_escape = 8'h0F;
    logic [7:0]   in_opcode = 8'hF8;
    logic         in_wide = 1'b1;
    logic [127:0] in_dst = '0;
    logic [127:0] in_src = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_result;
    logic         out_illegal;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 1'b0;
    logic [127:0] last_legal = '0;

    always #2.5 clk = ~clk;

    packed_sub_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_escape(in_escape), .in_opcode(in_opcode), .in_wide(in_wide),
        .in_dst(in_dst), .in_src(in_src), .out_valid(out_valid),
        .out_ready(out_ready), .out_result(out_result), .out_illegal(out_illegal)
    );

    function automatic int lane_bits(input logic [7:0] esc, input logic [7:0] opc);
        if (esc != 8'h0F) return 0;
        case (opc)
            8'hF8: return 8;
            8'hF9: return 16;
            8'hFA: return 32;
            default: return 0;
        endcase
    endfunction

    function automatic logic [127:0] ref_sub(input logic [127:0] d, input logic [127:0] s,
                                             input int lw, input bit wide);
        logic [127:0] r;
        logic [127:0] m;
        int total;
        r = '0;
        total = wide ? 128 : 64;
        m = (128'd1 << lw) - 128'd1;
        for (int o = 0; o < total; o += lw) begin
            r = r | (((((d >> o) & m) - ((s >> o) & m)) & m) << o);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    endtask

    // single operation with out_ready=1; checks after one edge
    task automatic xfer(input logic [7:0] esc, input logic [7:0] opc, input bit wide,
                        input logic [127:0] d, input logic [127:0] s, input string tag);
        int lw;
        logic [127:0] exp;
        lw = lane_bits(esc, opc);
        @(negedge clk);
        in_escape = esc; in_opcode = opc; in_wide = wide; in_dst = d; in_src = s;
        in_valid = 1'b1;
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (lw != 0) begin
            exp = ref_sub(d, s, lw, wide);
            last_legal = exp;
        end else begin
            exp = last_legal;
        end
        check(out_valid == 1'b1, {tag, " R7 valid"}, 128'(out_valid), 128'd1);
        check(out_illegal == (lw == 0), {tag, " R6 illegal flag"}, 128'(out_illegal), 128'(lw == 0));
        check(out_result == exp, {tag, " result"}, out_result, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL watchdog R7 actual=%h expected=%h", 0, 1);
        finish_run();
    end

    initial begin
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] ea;
        logic [127:0] eb;
        void'($urandom(32'h1234ABCD));

        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R9 out_valid", 128'(out_valid), 0);
        check(out_illegal == 1'b0, "R9 out_illegal", 128'(out_illegal), 0);
        check(out_result == '0, "R9 out_result", out_result, 0);
        check(in_ready == 1'b1, "R9 in_ready", 128'(in_ready), 1);
        rst_n = 1'b1;

        // R1: direction
        xfer(8'h0F, 8'hF8, 1'b1, {16{8'h05}}, {16{8'h03}}, "R1 byte 5-3");
        xfer(8'h0F, 8'hFA, 1'b0, 128'h0000_0007_0000_000A, 128'h0000_0002_0000_0001, "R1 dword narrow");

        // R5: borrow isolation, every lane width, wide and narrow
        xfer(8'h0F, 8'hF8, 1'b1, '0, {16{8'h01}}, "R5 byte borrow");
        xfer(8'h0F, 8'hF9, 1'b1, '0, {8{16'h0001}}, "R5 word borrow");
        xfer(8'h0F, 8'hFA, 1'b1, '0, {4{32'h0000_0001}}, "R5 dword borrow");
        xfer(8'h0F, 8'hF8, 1'b1, {16{8'h80}}, {16{8'h01}}, "R5 byte wrap 80-01");

        // R2: same operands, different lane widths give different results
        xfer(8'h0F, 8'hF8, 1'b1, {8{16'h0100}}, {8{16'h0001}}, "R2 byte lanes");
        check(out_result == {8{16'h01FF}}, "R2 byte pattern", out_result, {8{16'h01FF}});
        xfer(8'h0F, 8'hF9, 1'b1, {8{16'h0100}}, {8{16'h0001}}, "R2 word lanes");
        check(out_result == {8{16'h00FF}}, "R2 word pattern", out_result, {8{16'h00FF}});

        // R3/R4: narrow mode zeroes upper half, wide mode processes it
        xfer(8'h0F, 8'hF9, 1'b0, {128{1'b1}}, '0, "R4 narrow");
        check(out_result[127:64] == '0, "R4 upper zero", {64'b0, out_result[127:64]}, 0);
        xfer(8'h0F, 8'hF9, 1'b1, {128{1'b1}}, '0, "R3 wide");
        check(out_result[127:64] == {64{1'b1}}, "R3 upper kept", {64'b0, out_result[127:64]},
              {64'b0, {64{1'b1}}});

        // R6: illegal opcode and illegal escape after a legal op
        xfer(8'h0F, 8'hFA, 1'b1, {4{32'h1000_0000}}, {4{32'h0000_0001}}, "R6 legal before");
        xfer(8'h0F, 8'hFB, 1'b1, '1, '0, "R6 bad opcode");
        xfer(8'h0E, 8'hF8, 1'b1, '1, '0, "R6 bad escape");

        // R8: back-to-back with drain and accept in the same cycle
        a = {8{16'h1234}}; b = {8{16'h0235}};
        ea = ref_sub(a, {16{8'h11}}, 8, 1'b1);
        eb = ref_sub(b, {8{16'h0300}}, 16, 1'b1);
        @(negedge clk);
        out_ready = 1'b1;
        in_escape = 8'h0F; in_opcode = 8'hF8; in_wide = 1'b1; in_dst = a; in_src = {16{8'h11}};
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(out_result == ea, "R8 b2b first", out_result, ea);
        check(in_ready == 1'b1, "R8 ready while draining", 128'(in_ready), 1);
        in_opcode = 8'hF9; in_dst = b; in_src = {8{16'h0300}};
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1 && out_result == eb, "R8 b2b second", out_result, eb);
        last_legal = eb;

        // R8: backpressure stall
        @(negedge clk);
        out_ready = 1'b0;
        in_opcode = 8'hF8; in_dst = {16{8'h44}}; in_src = {16{8'h04}};
        in_valid = 1'b1;
        ea = {16{8'h40}};
        @(posedge clk);
        @(negedge clk);
        check(out_result == ea, "R8 stall first", out_result, ea);
        in_opcode = 8'hFA; in_dst = {4{32'h0000_0010}}; in_src = {4{32'h0000_0020}};
        eb = {4{32'hFFFF_FFF0}};
        for (int k = 0; k < 3; k++) begin
            check(in_ready == 1'b0, "R8 in_ready low", 128'(in_ready), 0);
            @(posedge clk);
            @(negedge clk);
            check(out_valid && out_result == ea, "R8 held", out_result, ea);
        end
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_result == eb, "R8 released accept", out_result, eb);
        last_legal = eb;

        // random
        for (int it = 0; it < 400; it++) begin
            logic [7:0] opc;
            logic [7:0] esc;
            int pick;
            pick = $urandom_range(0, 9);
            opc = (pick < 3) ? 8'hF8 : (pick < 6) ? 8'hF9 : (pick < 9) ? 8'hFA : 8'($urandom);
            esc = ($urandom_range(0, 19) == 0) ? 8'h3C : 8'h0F;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = {$urandom, $urandom, $urandom, $urandom};
            xfer(esc, opc, 1'($urandom), a, b, "R1 R5 random");
        end

        @(negedge clk);
        finish_run();
    end

endmodule